// File: doc/BRIEF.md
# Speculative Block Address Lookup Table

This block keeps a small, fully associative record of the cache blocks that speculatively retired loads and stores have touched while an earlier store is still outstanding. Each block appears in one entry only. The entry holds two flags, one for loads and one for stores. It also holds the history-log position of the earliest instruction that touched the block, and a count of the log entries that still refer to it. Coherence traffic arriving from outside can then be screened in a single lookup instead of a search of the whole history log.

The insert side records each speculative access as it retires into the log. The release side reports each discarded log entry by block address. The log can wipe the whole table when it rolls back.

An external event names an address and a kind: invalidation, remote read, replacement or downgrade. The block raises a rollback request one cycle later and reports the log position to restore to. A remote read requests a rollback only for a block that holds speculatively stored data. The other kinds request one for any tracked block. Events that match no entry are dismissed.

Top module: `spec_block_table`

## Requirements
- R1: A block address occupies at most one entry. Further accesses to a tracked block share that entry and add one to its reference count.
- R2: Addresses are compared at block granularity. With the default OFS_W of 6, the low 6 bits of every address are ignored.
- R3: An event of kind 0 (invalidation), 2 (replacement) or 3 (downgrade) that hits a tracked entry sets rb_valid in the following cycle.
- R4: An event of kind 1 (remote read) sets rb_valid in the following cycle only if the hit entry has seen at least one store (ins_store=1). An entry that has only seen loads causes no rollback.
- R5: rb_idx carries the ins_idx of the insert that created the entry. Later inserts to the same block leave it unchanged while the entry lives. rb_idx is zero whenever rb_valid is 0.
- R6: An event whose block matches no entry leaves rb_valid at 0 in the following cycle.
- R7: When every entry is live and an insert names an untracked block, ins_stall is 1 in the same cycle and the insert is dropped. An insert to a tracked block is still accepted.
- R8: A release to a tracked block subtracts one from its count. At zero the entry is freed and later events to that block miss. A release to an untracked block has no effect.
- R9: A flush empties the table, and flush takes priority over an insert or release in the same cycle.
- R10: An event sees the table as it stood before the edge. An insert and an event to the same new block in one cycle give no rollback. An insert and a release to one tracked entry in the same cycle leave its count unchanged.
- R11: Out of reset the table is empty, rb_valid is 0 and ins_stall is 0.
- R12: An insert to a tracked block whose count is at its maximum (2^CNT_W-1) raises ins_stall and is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Speculative access retired into the log |
| ins_addr | input | ADDR_W | Byte address of the access |
| ins_store | input | 1 | 1 for a store, 0 for a load |
| ins_idx | input | IDX_W | Log position of the access |
| ins_stall | output | 1 | Insert not accepted this cycle |
| rel_valid | input | 1 | One log entry discarded |
| rel_addr | input | ADDR_W | Address of the discarded log entry |
| flush | input | 1 | Log rollback: clear the table |
| evt_valid | input | 1 | External coherence event |
| evt_addr | input | ADDR_W | Event address |
| evt_kind | input | 2 | 0 invalidation, 1 remote read, 2 replacement, 3 downgrade |
| rb_valid | output | 1 | Rollback requested (registered) |
| rb_idx | output | IDX_W | Log position to roll back to |

## Verification
The sensitive overlap is an external event that lands in the same cycle as an insert or release touching the same block. The lookup must use the table as it stood before that edge. Directed cycles place an insert of a new block beside an invalidation of it, and an insert beside a release of one entry. A long random phase draws inserts, releases and events from a pool of eight blocks, so such collisions happen often. The behavioural model applies every event to the pre-edge state and the insert before the release, and it compares ins_stall, rb_valid and rb_idx every cycle.

// File: rtl/spec_block_table.sv
module spec_block_table #(
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 6,
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 8,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              ins_store,
  input  logic [IDX_W-1:0]  ins_idx,
  output logic              ins_stall,
  input  logic              rel_valid,
  input  logic [ADDR_W-1:0] rel_addr,
  input  logic              flush,
  input  logic              evt_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [1:0]        evt_kind,
  output logic              rb_valid,
  output logic [IDX_W-1:0]  rb_idx
);
  localparam int TAG_W  = ADDR_W - OFS_W;
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [1:0] K_RREAD = 2'd1;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [IDX_W-1:0] idx_q [ENTRIES];
  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [ENTRIES-1:0] ld_q, st_q, live, ins_hit, rel_hit, evt_hit, at_max;

  wire [TAG_W-1:0] ins_tag = ins_addr[ADDR_W-1:OFS_W];
  wire [TAG_W-1:0] rel_tag = rel_addr[ADDR_W-1:OFS_W];
  wire [TAG_W-1:0] evt_tag = evt_addr[ADDR_W-1:OFS_W];
  wire unused_low = ^{ins_addr[OFS_W-1:0], rel_addr[OFS_W-1:0], evt_addr[OFS_W-1:0]};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign live[i]    = cnt_q[i] != '0;
    assign ins_hit[i] = live[i] && tag_q[i] == ins_tag;
    assign rel_hit[i] = live[i] && tag_q[i] == rel_tag;
    assign evt_hit[i] = live[i] && tag_q[i] == evt_tag;
    assign at_max[i]  = cnt_q[i] == CNT_MAX;
  end

  wire ins_any = |ins_hit;
  wire full    = &live;
  assign ins_stall = ins_valid && ((!ins_any && full) || |(ins_hit & at_max));
  wire ins_ok  = ins_valid && !ins_stall;
  wire alloc   = ins_ok && !ins_any;

  logic [SLOT_W-1:0] free_slot;
  logic [IDX_W-1:0]  evt_idx;
  always_comb begin
    free_slot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!live[i]) free_slot = SLOT_W'(i);
    evt_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (evt_hit[i]) evt_idx = evt_idx | idx_q[i];
  end

  wire evt_ld = |(evt_hit & ld_q);
  wire evt_st = |(evt_hit & st_q);
  wire viol   = evt_valid && ((evt_kind == K_RREAD) ? evt_st : (evt_ld || evt_st));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int i = 0; i < ENTRIES; i++) begin
        cnt_q[i] <= '0;
        tag_q[i] <= '0;
        idx_q[i] <= '0;
      end
      ld_q <= '0;
      st_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        logic inc, dec, take;
        take = alloc && free_slot == SLOT_W'(i);
        inc  = (ins_ok && ins_hit[i]) || take;
        dec  = rel_valid && rel_hit[i];
        cnt_q[i] <= cnt_q[i] + CNT_W'(inc) - CNT_W'(dec);
        if (take) begin
          tag_q[i] <= ins_tag;
          idx_q[i] <= ins_idx;
          ld_q[i]  <= !ins_store;
          st_q[i]  <= ins_store;
        end else if (ins_ok && ins_hit[i]) begin
          ld_q[i] <= ld_q[i] | !ins_store;
          st_q[i] <= st_q[i] | ins_store;
        end else if (dec && cnt_q[i] == CNT_W'(1)) begin
          ld_q[i] <= 1'b0;
          st_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_valid <= 1'b0;
      rb_idx   <= '0;
    end else begin
      rb_valid <= viol;
      rb_idx   <= viol ? evt_idx : '0;
    end
  end

  assert_unique_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> $onehot0(ins_hit));
  assert_event_unique_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $onehot0(evt_hit));
  assert_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_hit == '0) |=> !rb_valid);
  assert_rread_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == K_RREAD && !evt_st) |=> !rb_valid);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_stall && !rel_valid && !flush) |=> $countones(live) == $past($countones(live)));
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> live == '0);
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_valid |-> rb_idx == '0);
endmodule

// File: tb/sim_spec_block_table.sv
module sim_spec_block_table;
  localparam int AW = 32, IW = 8, NENT = 64, CMAX = 15;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_store = 0, rel_valid = 0, flush = 0, evt_valid = 0;
  logic [AW-1:0] ins_addr = 0, rel_addr = 0, evt_addr = 0;
  logic [IW-1:0] ins_idx = 0;
  logic [1:0] evt_kind = 0;
  logic ins_stall, rb_valid;
  logic [IW-1:0] rb_idx;

  always #5 clk = ~clk;

  spec_block_table u0 (.clk, .rst_n, .ins_valid, .ins_addr, .ins_store, .ins_idx,
    .ins_stall, .rel_valid, .rel_addr, .flush, .evt_valid, .evt_addr, .evt_kind,
    .rb_valid, .rb_idx);

  int tests = 0, fails = 0;
  int m_cnt[int], m_idx[int];
  bit m_ld[int], m_st[int];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit iv, int ia, bit ist, int iidx, bit rv, int ra,
                      bit ev, int ea, int ek, bit fl, string req);
    int it, rt, et, erb, eidx;
    bit estall, rex;
    ins_valid = iv; ins_addr = ia; ins_store = ist; ins_idx = IW'(iidx);
    rel_valid = rv; rel_addr = ra; evt_valid = ev; evt_addr = ea; evt_kind = 2'(ek);
    flush = fl;
    it = ia >>> 6; rt = ra >>> 6; et = ea >>> 6;
    estall = iv && ((!m_cnt.exists(it) && m_cnt.num() == NENT) ||
                    (m_cnt.exists(it) && m_cnt[it] == CMAX));
    #1 chk(ins_stall == estall, req, "ins_stall", ins_stall, estall);
    @(posedge clk);
    erb = 0; eidx = 0;
    if (ev && m_cnt.exists(et))
      if (ek == 1 ? m_st[et] : (m_ld[et] || m_st[et])) begin erb = 1; eidx = m_idx[et]; end
    rex = m_cnt.exists(rt);
    if (fl) begin
      m_cnt.delete(); m_idx.delete(); m_ld.delete(); m_st.delete();
    end else begin
      if (iv && !estall) begin
        if (m_cnt.exists(it)) begin
          m_cnt[it]++; m_ld[it] |= !ist; m_st[it] |= ist;
        end else begin
          m_cnt[it] = 1; m_idx[it] = iidx; m_ld[it] = !ist; m_st[it] = ist;
        end
      end
      if (rv && rex) begin
        m_cnt[rt]--;
        if (m_cnt[rt] == 0) begin
          m_cnt.delete(rt); m_idx.delete(rt); m_ld.delete(rt); m_st.delete(rt);
        end
      end
    end
    @(negedge clk);
    chk(rb_valid == erb, req, "rb_valid", rb_valid, erb);
    chk(rb_idx == IW'(eidx), req, "rb_idx", rb_idx, eidx);
  endtask

  task automatic ins(int a, bit st, int idx, string req);
    step(1, a, st, idx, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic evt(int a, int k, string req);
    step(0, 0, 0, 0, 0, 0, 1, a, k, 0, req);
  endtask
  task automatic rel(int a, string req);
    step(0, 0, 0, 0, 1, a, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R11: reset state
    chk(rb_valid == 0, "R11", "rb_valid", rb_valid, 0);
    chk(ins_stall == 0, "R11", "ins_stall", ins_stall, 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 1, 'h40, 0, 0, "R11");
    // R4 R5 R2 R3
    ins('h1000, 0, 5, "R1");
    ins('h1008, 0, 7, "R2");
    evt('h1000, 1, "R4");
    ins('h1030, 1, 9, "R5");
    evt('h1004, 1, "R4");
    evt('h103f, 0, "R2");
    evt('h1000, 2, "R3");
    evt('h1000, 3, "R3");
    evt('h2000, 0, "R6");
    ins('h2000, 0, 20, "R1");
    evt('h2010, 2, "R3");
    evt('h2010, 1, "R4");
    // R8 release path
    rel('h1000, "R8"); rel('h1000, "R8");
    evt('h1000, 0, "R8");
    rel('h1000, "R8");
    evt('h1000, 0, "R8");
    rel('h5000, "R8");
    evt('h2000, 0, "R8");
    // R10 same-cycle overlap
    step(1, 'h3000, 1, 33, 0, 0, 1, 'h3000, 0, 0, "R10");
    evt('h3000, 0, "R10");
    step(1, 'h3000, 0, 34, 1, 'h3000, 1, 'h3000, 1, 0, "R10");
    rel('h3000, "R10");
    evt('h3000, 0, "R10");
    // R9 flush
    step(1, 'h4000, 1, 40, 0, 0, 0, 0, 0, 1, "R9");
    evt('h2000, 0, "R9");
    evt('h4000, 0, "R9");
    // R7 fill all entries
    for (int i = 0; i < NENT; i++) ins('h10000 + i * 64, i[0], i, "R7");
    ins('h90000, 0, 99, "R7");
    evt('h90000, 0, "R7");
    ins('h10000, 1, 100, "R7");
    // R12 saturation of one entry (count now 2)
    for (int i = 0; i < 13; i++) ins('h10000, 0, 101, "R12");
    ins('h10000, 0, 102, "R12");
    evt('h10000, 0, "R12");
    rel('h10040, "R8");
    ins('h90000, 1, 77, "R7");
    evt('h90000, 1, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    // random mix: collisions of insert, release and event
    for (int n = 0; n < 3000; n++) begin
      int ba, bb, bc;
      ba = 'h8000 + int'($urandom_range(0, 7)) * 64 + int'($urandom_range(0, 63));
      bb = 'h8000 + int'($urandom_range(0, 7)) * 64;
      bc = 'h8000 + int'($urandom_range(0, 7)) * 64 + int'($urandom_range(0, 63));
      step($urandom_range(0, 1), ba, $urandom_range(0, 1), $urandom_range(0, 255),
           $urandom_range(0, 2) == 0, bb, $urandom_range(0, 1), bc,
           $urandom_range(0, 3), $urandom_range(0, 99) == 0, "R10");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule